// File: doc/BRIEF.md
# Two-Way Message FIFO Mailbox

This block carries short messages between a host processor and an embedded core. It holds two FIFOs. The host fills the inbound FIFO and the core drains it. The core fills the outbound FIFO and the host drains it. A message is a pair of 32-bit words. Before the first word the host checks that the inbound FIFO is empty, and before the second word it checks that the FIFO is not full, so the inbound FIFO must hold at least two words.

The host sees four registers, chosen by `host_sel`. A single data register pushes inbound on a write and pops outbound on a read. A status word reports the fill state of both directions and four interrupt flags. A control word holds a per-direction enable and a per-direction write permission. The fourth register is a mailbox that the core posts to and the host clears with a fixed key value. The core side has its own pop, push and mailbox-post strobes. Host reads return data in the same cycle, and every register update takes effect at the next rising clock edge.

Top module: `msg_fifo_mbox`

## Requirements
- R1: A host write with `host_sel`=0 pushes `host_wdata` into the inbound FIFO if control bit 25 (inbound write permission) is set. `core_rdata` shows the oldest inbound word, and `core_pop` removes it, in first-in first-out order.
- R2: A core push (`core_push`) adds `core_wdata` to the outbound FIFO if control bit 24 (outbound write permission) is set. While `host_sel`=0, `host_rdata` shows the oldest outbound word, and a host read with `host_sel`=0 removes it.
- R3: Each FIFO holds DEPTH (default 4) words. A push to a full FIFO is dropped and leaves the contents unchanged. A pop and a push in the same cycle on a full FIFO accept only the pop.
- R4: A pop from an empty FIFO has no effect, and the data seen on that path reads zero.
- R5: The status word (`host_sel`=1) has outbound-not-empty at bit 16, inbound-not-full at bit 17, outbound-not-full at bit 18 and inbound-not-empty at bit 19. Bits 16 and 18 read 0 while control bit 16 (outbound enable) is clear. Bits 17 and 19 read 0 while control bit 17 (inbound enable) is clear.
- R6: The interrupt flags are level signals. They appear in the status word at bits 20 (mailbox pending), 21 (inbound: not empty and inbound enabled), 22 (outbound: not empty and outbound enabled) and 23 (the `core_watch` input), and on `flags[3:0]` in that same order.
- R7: The control word (`host_sel`=2) resets to 0x03030000. Only bits 16, 17, 24 and 25 are writable, and all other bits read 0.
- R8: The mailbox word (`host_sel`=3) resets to 0. `core_mbox_wr` loads `core_wdata` into it and sets mailbox pending. A host write of exactly 0x0000F0F0 clears the word and the pending flag, and this takes priority over a core post in the same cycle. Any other host write to the mailbox is ignored.
- R9: After reset both FIFOs are empty, so the status word reads 0x00060000 when `core_watch` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 2 | Host register select: 0 data, 1 status, 2 control, 3 mailbox |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops outbound when host_sel is 0) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected register |
| core_pop | input | 1 | Core removes the oldest inbound word |
| core_rdata | output | 32 | Oldest inbound word, or zero when the FIFO is empty |
| core_push | input | 1 | Core pushes core_wdata into the outbound FIFO |
| core_mbox_wr | input | 1 | Core posts core_wdata to the mailbox |
| core_wdata | input | 32 | Core write data |
| core_watch | input | 1 | Watch event level, reported as flag bit 3 |
| flags | output | 4 | Level interrupt flags: {watch, outbound, inbound, mailbox} |

## Verification
The bench targets the full and empty edges of both FIFOs, including a pop and a push in the same cycle on a full FIFO. A design that counted wrongly there would either overwrite the oldest word or return stale data instead of zero. It toggles the enable and permission bits while traffic is flowing. A design with a gating error would report fill state or raise a flag for a disabled direction, or would accept pushes it should refuse. It also mixes mailbox clear keys, non-key writes and same-cycle core posts. A design with the wrong priority would leave the pending flag set after a clear, or would clear it on the wrong value.

// File: rtl/msg_fifo_mbox.sv
module msg_fifo_mbox #(
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          core_pop,
  output logic [DW-1:0] core_rdata,
  input  logic          core_push,
  input  logic          core_mbox_wr,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_watch,
  output logic [3:0]    flags
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [DW-1:0] CLR_KEY = DW'(32'h0000F0F0);

  logic [DW-1:0] in_mem [DEPTH];
  logic [DW-1:0] out_mem[DEPTH];
  logic [AW-1:0] in_rp, in_wp, out_rp, out_wp;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          out_en, in_en, out_wen, in_wen;
  logic [DW-1:0] mbox_q;
  logic          mbox_pend;

  wire sel_data = host_sel == 2'd0;
  wire in_ne    = in_cnt != '0;
  wire in_nf    = in_cnt != FULL;
  wire out_ne   = out_cnt != '0;
  wire out_nf   = out_cnt != FULL;
  wire in_push  = host_wr && sel_data && in_wen && in_nf;
  wire in_pop   = core_pop && in_ne;
  wire out_push = core_push && out_wen && out_nf;
  wire out_pop  = host_rd && sel_data && out_ne;
  wire mbox_clr = host_wr && host_sel == 2'd3 && host_wdata == CLR_KEY;

  assign flags = {core_watch, out_en && out_ne, in_en && in_ne, mbox_pend};
  assign core_rdata = in_ne ? in_mem[in_rp] : '0;

  logic [31:0] status_w, ctrl_w;
  always_comb begin
    status_w = '0;
    status_w[16] = out_en && out_ne;
    status_w[17] = in_en && in_nf;
    status_w[18] = out_en && out_nf;
    status_w[19] = in_en && in_ne;
    status_w[23:20] = flags;
    ctrl_w = '0;
    ctrl_w[16] = out_en;
    ctrl_w[17] = in_en;
    ctrl_w[24] = out_wen;
    ctrl_w[25] = in_wen;
  end

  always_comb begin
    case (host_sel)
      2'd0:    host_rdata = out_ne ? out_mem[out_rp] : '0;
      2'd1:    host_rdata = DW'(status_w);
      2'd2:    host_rdata = DW'(ctrl_w);
      default: host_rdata = mbox_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (in_push)  in_mem[in_wp]   <= host_wdata;
    if (out_push) out_mem[out_wp] <= core_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rp <= '0; in_wp <= '0; in_cnt <= '0;
      out_rp <= '0; out_wp <= '0; out_cnt <= '0;
      out_en <= 1'b1; in_en <= 1'b1; out_wen <= 1'b1; in_wen <= 1'b1;
      mbox_q <= '0; mbox_pend <= 1'b0;
    end else begin
      if (in_push)  in_wp  <= (in_wp == LAST) ? '0 : in_wp + 1'b1;
      if (in_pop)   in_rp  <= (in_rp == LAST) ? '0 : in_rp + 1'b1;
      if (out_push) out_wp <= (out_wp == LAST) ? '0 : out_wp + 1'b1;
      if (out_pop)  out_rp <= (out_rp == LAST) ? '0 : out_rp + 1'b1;
      in_cnt  <= in_cnt + CW'(in_push) - CW'(in_pop);
      out_cnt <= out_cnt + CW'(out_push) - CW'(out_pop);
      if (host_wr && host_sel == 2'd2) begin
        out_en  <= host_wdata[16];
        in_en   <= host_wdata[17];
        out_wen <= host_wdata[24];
        in_wen  <= host_wdata[25];
      end
      if (mbox_clr) begin
        mbox_q <= '0; mbox_pend <= 1'b0;
      end else if (core_mbox_wr) begin
        mbox_q <= core_wdata; mbox_pend <= 1'b1;
      end
    end
  end

  // R3
  in_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_nf && host_wr && sel_data && !core_pop) |=> (in_cnt == FULL && $stable(in_rp)));
  // R4
  out_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ne && sel_data) |-> (host_rdata == '0));
  // R4
  in_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ne && core_pop && !(host_wr && sel_data)) |=> (in_cnt == '0));
  // R6
  in_flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_en |-> !flags[1] && !host_rdata[19] || host_sel != 2'd1);
  // R6
  out_flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !flags[2]);
  // R8
  mbox_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_clr |=> (mbox_q == '0 && !flags[0]));
endmodule

// File: tb/msg_fifo_mbox_tb.sv
`timescale 1ns/1ps
module msg_fifo_mbox_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] host_sel = 0;
  logic host_wr = 0, host_rd = 0, core_pop = 0, core_push = 0, core_mbox_wr = 0, core_watch = 0;
  logic [31:0] host_wdata = 0, core_wdata = 0, host_rdata, core_rdata;
  logic [3:0] flags;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  msg_fifo_mbox dut_i (.clk, .rst_n, .host_sel, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .core_pop, .core_rdata, .core_push, .core_mbox_wr, .core_wdata, .core_watch, .flags);

  logic [31:0] inq[$], outq[$], mbox;
  bit oen, ien, owp, iwp, pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inq.delete(); outq.delete(); mbox = 0; pend = 0;
      oen = 1; ien = 1; owp = 1; iwp = 1;
    end else begin
      bit ipush, ipop, opush, opop;
      ipop  = core_pop && inq.size() > 0;
      ipush = host_wr && host_sel == 0 && iwp && inq.size() < 4;
      opop  = host_rd && host_sel == 0 && outq.size() > 0;
      opush = core_push && owp && outq.size() < 4;
      if (ipop) void'(inq.pop_front());
      if (ipush) inq.push_back(host_wdata);
      if (opop) void'(outq.pop_front());
      if (opush) outq.push_back(core_wdata);
      if (host_wr && host_sel == 2) begin
        oen = host_wdata[16]; ien = host_wdata[17]; owp = host_wdata[24]; iwp = host_wdata[25];
      end
      if (host_wr && host_sel == 3 && host_wdata == 32'h0000F0F0) begin mbox = 0; pend = 0; end
      else if (core_mbox_wr) begin mbox = core_wdata; pend = 1; end
    end
  end

  function automatic logic [31:0] m_status();
    logic [31:0] s = 0;
    if (oen) begin s[16] = outq.size() > 0; s[18] = outq.size() < 4; end
    if (ien) begin s[17] = inq.size() < 4; s[19] = inq.size() > 0; end
    s[20] = pend; s[21] = ien && inq.size() > 0; s[22] = oen && outq.size() > 0; s[23] = core_watch;
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] s, c;
    s = m_status();
    c = {6'd0, iwp, owp, 6'd0, ien, oen, 16'd0};
    chk(inq.size() > 0 ? "R1 core_rdata" : "R4 core_rdata empty", core_rdata, inq.size() > 0 ? inq[0] : 0);
    chk("R6 flags", {28'd0, flags}, {28'd0, s[23:20]});
    case (host_sel)
      0: chk(outq.size() > 0 ? "R2 host data" : "R4 host data empty", host_rdata, outq.size() > 0 ? outq[0] : 0);
      1: chk("R5 status", host_rdata, s);
      2: chk("R7 control", host_rdata, c);
      default: chk("R8 mailbox", host_rdata, mbox);
    endcase
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; core_pop = 0; core_push = 0; core_mbox_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    host_sel = 1; #1;
    chk("R9 reset status", host_rdata, 32'h00060000);
    host_sel = 2; #1;
    chk("R7 reset control", host_rdata, 32'h03030000);
    host_sel = 3; #1;
    chk("R8 reset mailbox", host_rdata, 0);
    rst_n = 1;
    // R3: five host pushes, the fifth is dropped
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk); compare();
      idle(); host_sel = 0; host_wr = 1; host_wdata = i;
    end
    @(negedge clk); compare();
    idle(); host_sel = 1; #1;
    chk("R3 full status", host_rdata, 32'h002C0000);
    // R3: pop and push together while full accepts only the pop
    host_sel = 0; host_wr = 1; host_wdata = 32'hAA; core_pop = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); compare();
      idle(); core_pop = 1;
    end
    @(negedge clk); compare(); idle();
    // R8: same-cycle clear key and core post, clear wins
    core_mbox_wr = 1; core_wdata = 32'h55; host_sel = 3;
    @(negedge clk); compare();
    host_wr = 1; host_wdata = 32'h0000F0F0;
    @(negedge clk); compare();
    idle(); host_wr = 1; host_wdata = 32'h0000F0F1;
    @(negedge clk); compare(); idle();
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk); compare();
      idle();
      host_sel   = 2'($urandom_range(0, 3));
      host_wr    = ($urandom_range(0, 3) == 0);
      host_rd    = ($urandom_range(0, 2) == 0);
      host_wdata = $urandom;
      if (host_sel == 3 && $urandom_range(0, 1)) host_wdata = 32'h0000F0F0;
      if (host_sel == 2 && $urandom_range(0, 3) != 0) host_wdata = 32'h03030000;
      if (host_sel == 1) host_wr = 0;
      core_pop     = ($urandom_range(0, 2) == 0);
      core_push    = ($urandom_range(0, 1) == 0);
      core_mbox_wr = ($urandom_range(0, 15) == 0);
      core_wdata   = $urandom;
      core_watch   = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk); compare();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule